// File: doc/BRIEF.md
# Per-Lane Variable Left Shifter

This block is a SIMD datapath that shifts every element of a 256-bit data vector left by its own amount. Each element takes its count from the element in the same position of a second 256-bit vector. Bits that move past the top of an element are lost, and the low bits left empty are filled with zeros. The count is read as an unsigned number over the whole element. A count at or above the element width therefore clears that element to zero instead of wrapping around.

Two control inputs set the operating mode. `elem64` chooses between eight 32-bit elements and four 64-bit elements. `wide` chooses between a full 256-bit operation and a 128-bit operation. In the 128-bit operation the upper half of the result is always zero.

The block is a parallel combinational shifter followed by an optional output register, selected by a parameter. With the register in place, a valid flag goes through the register alongside the data, so a result appears one cycle after its operands.

Top module: `vshl_unit`

## Requirements
- R1: With `elem64`=0, each 32-bit element k (bits 32k+31:32k) of the result equals data element k shifted left by count element k, where that count is 0..31.
- R2: With `elem64`=1, each 64-bit element k (bits 64k+63:64k) of the result equals data element k shifted left by count element k, where that count is 0..63.
- R3: Bits shifted past the top of an element are discarded and never enter the neighbouring element. Vacated low bits are 0.
- R4: With `elem64`=0, a 32-bit count element whose unsigned value is above 31 forces that result element to zero. Every bit of the 32-bit count element is taken into account.
- R5: With `elem64`=1, a 64-bit count element whose unsigned value is above 63 forces that result element to zero. Every bit of the 64-bit count element is taken into account, so 0x1_0000_0001 clears the element.
- R6: With `wide`=0, only bits 127:0 are computed and result bits 255:128 are 0. With `wide`=1, all elements are processed.
- R7: A count element of zero passes its data element through unchanged.
- R8: With the output register (default), `result` and `valid_out` reflect the inputs sampled on the previous rising edge when `valid_in` was 1. When `valid_in` is 0, `valid_out` goes to 0 on the next edge and `result` holds its value.
- R9: A synchronous active-high `rst` clears `result` to zero and `valid_out` to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands are valid this cycle |
| elem64 | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| wide | input | 1 | 0: 128-bit operation, 1: 256-bit operation |
| data_in | input | 256 | Vector to be shifted |
| count_in | input | 256 | Per-element shift counts |
| valid_out | output | 1 | Result is valid |
| result | output | 256 | Shifted vector |

## Verification
The hardest case to reach is a count whose low bits look like a legal shift while a high bit of the element is set. Random 32- or 64-bit counts almost never produce this shape. Random counts also almost never land near the element width. The bench therefore builds each count element from a weighted choice of 0, width-1, width, width+1, a small in-range value, and a value with a single high bit set above a small low part. It runs these choices in both element sizes and both operation widths. The bench also drives non-zero data into the upper half during 128-bit operations, so that any leakage into bits 255:128 shows up.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
    localparam int VEC_W = 256;

    typedef enum logic { ESZ_32 = 1'b0, ESZ_64 = 1'b1 } elem_size_e;
    typedef enum logic { OPW_128 = 1'b0, OPW_256 = 1'b1 } op_width_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] value;
    } vec_beat_t;

    function automatic int lane_count(input int vec_w, input int lane_w);
        return vec_w / lane_w;
    endfunction
endpackage

// File: rtl/vshl_lane.sv
module vshl_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] data,
    input  logic [LANE_W-1:0] cnt,
    output logic [LANE_W-1:0] res
);
    localparam int SH_W = $clog2(LANE_W);

    logic too_far;
    logic [SH_W-1:0] amount;

    always_comb begin
        too_far = |cnt[LANE_W-1:SH_W];
        amount  = cnt[SH_W-1:0];
        res     = too_far ? '0 : (data << amount);
    end
endmodule

// File: rtl/vshl_stage.sv
module vshl_stage
    import vshl_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  vec_beat_t d,
    output vec_beat_t q
);
    generate
        if (REG_OUT) begin : g_reg
            vec_beat_t held;
            always_ff @(posedge clk) begin
                if (rst) begin
                    held <= '0;
                end else begin
                    held.valid <= d.valid;
                    if (d.valid) held.value <= d.value;
                end
            end
            assign q = held;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/vshl_unit.sv
module vshl_unit
    import vshl_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic             elem64,
    input  logic             wide,
    input  logic [VEC_W-1:0] data_in,
    input  logic [VEC_W-1:0] count_in,
    output logic             valid_out,
    output logic [VEC_W-1:0] result
);
    localparam int N32  = lane_count(VEC_W, 32);
    localparam int N64  = lane_count(VEC_W, 64);
    localparam int HALF = VEC_W / 2;

    elem_size_e esz;
    op_width_e  opw;
    assign esz = elem_size_e'(elem64);
    assign opw = op_width_e'(wide);

    logic [VEC_W-1:0] res32, res64, shifted;
    vec_beat_t        beat_d, beat_q;

    genvar i;
    generate
        for (i = 0; i < N32; i++) begin : g_l32
            vshl_lane #(.LANE_W(32)) u_lane (
                .data(data_in[i*32 +: 32]),
                .cnt (count_in[i*32 +: 32]),
                .res (res32[i*32 +: 32])
            );
        end
        for (i = 0; i < N64; i++) begin : g_l64
            vshl_lane #(.LANE_W(64)) u_lane (
                .data(data_in[i*64 +: 64]),
                .cnt (count_in[i*64 +: 64]),
                .res (res64[i*64 +: 64])
            );
        end
    endgenerate

    always_comb begin
        shifted = (esz == ESZ_64) ? res64 : res32;
        if (opw == OPW_128) shifted[VEC_W-1:HALF] = '0;
        beat_d.valid = valid_in;
        beat_d.value = shifted;
    end

    vshl_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk(clk),
        .rst(rst),
        .d  (beat_d),
        .q  (beat_q)
    );

    assign valid_out = beat_q.valid;
    assign result    = beat_q.value;

    generate
        if (REG_OUT) begin : g_chk
            // R9
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (result == '0 && !valid_out));
            // R8
            valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
                valid_in |=> valid_out);
            // R8
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                !valid_in |=> (!valid_out && $stable(result)));
            // R6
            upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (valid_in && !wide) |=> (result[VEC_W-1:HALF] == '0));
            for (i = 0; i < N32; i++) begin : g_c32
                // R4
                oor32_chk: assert property (@(posedge clk) disable iff (rst)
                    (valid_in && !elem64 && (|count_in[i*32+5 +: 27]))
                    |=> (result[i*32 +: 32] == '0));
                // R7
                pass32_chk: assert property (@(posedge clk) disable iff (rst)
                    (valid_in && !elem64 && count_in[i*32 +: 32] == '0 && (wide || i < N32/2))
                    |=> (result[i*32 +: 32] == $past(data_in[i*32 +: 32])));
            end
            for (i = 0; i < N64; i++) begin : g_c64
                // R5
                oor64_chk: assert property (@(posedge clk) disable iff (rst)
                    (valid_in && elem64 && (|count_in[i*64+6 +: 58]))
                    |=> (result[i*64 +: 64] == '0));
            end
        end
    endgenerate
endmodule

// File: tb/vshl_unit_test.sv
module vshl_unit_test;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic         elem64 = 1'b0;
    logic         wide = 1'b1;
    logic [255:0] data_in = '0;
    logic [255:0] count_in = '0;
    logic         valid_out;
    logic [255:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [255:0] last_exp = '0;

    always #(PERIOD/2) clk = ~clk;

    vshl_unit uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .elem64(elem64), .wide(wide),
        .data_in(data_in), .count_in(count_in), .valid_out(valid_out), .result(result)
    );

    function automatic logic [255:0] model(input logic [255:0] d, input logic [255:0] c,
                                           input logic e64, input logic w);
        logic [255:0] r = '0;
        int lw = e64 ? 64 : 32;
        int n  = (w ? 256 : 128) / lw;
        for (int k = 0; k < n; k++) begin
            logic [63:0] dv = '0, cv = '0, rv;
            for (int b = 0; b < lw; b++) begin
                dv[b] = d[k*lw + b];
                cv[b] = c[k*lw + b];
            end
            if (cv >= 64'(lw)) rv = '0;
            else rv = dv << cv;
            for (int b = 0; b < lw; b++) r[k*lw + b] = rv[b];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [255:0] exp, input logic expv);
        checks++;
        if (result !== exp || valid_out !== expv) begin
            errors++;
            $display("FAIL %s result=%h valid=%b expected=%h valid=%b", tag, result, valid_out, exp, expv);
        end
    endtask

    task automatic apply(input string tag, input logic e64, input logic w,
                         input logic [255:0] d, input logic [255:0] c);
        logic [255:0] exp;
        elem64 = e64; wide = w; data_in = d; count_in = c; valid_in = 1'b1;
        exp = model(d, c, e64, w);
        @(negedge clk);
        check(tag, exp, 1'b1);
        last_exp = exp;
    endtask

    function automatic logic [63:0] pick_count(input int lw);
        int s = $urandom_range(0, 6);
        case (s)
            0: return 64'd0;
            1: return 64'(lw - 1);
            2: return 64'(lw);
            3: return 64'(lw + 1);
            4: return 64'(1) << $urandom_range(lw/2 - 1, lw - 1) | 64'($urandom_range(0, 3));
            default: return 64'($urandom_range(0, lw - 1));
        endcase
    endfunction

    function automatic logic [255:0] rand_vec();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [255:0] d, c;
        @(negedge clk); @(negedge clk);
        check("R9 reset", '0, 1'b0);
        rst = 1'b0;

        // R1 R3: 32-bit lanes, distinct counts, overflow bits discarded
        d = {8{32'hF000_0001}};
        c = '0;
        for (int k = 0; k < 8; k++) c[k*32 +: 32] = 32'(k * 4);
        apply("R1 R3 lane32", 1'b0, 1'b1, d, c);
        // R2 R3: 64-bit lanes
        d = {4{64'h8000_0000_0000_0003}};
        c = {64'd63, 64'd1, 64'd32, 64'd5};
        apply("R2 R3 lane64", 1'b1, 1'b1, d, c);
        // R4: high count bit in 32-bit element; boundaries 31,32,33
        d = {8{32'hFFFF_FFFF}};
        c = {32'h8000_0001, 32'd31, 32'd32, 32'd33, 32'h0001_0000, 32'd1, 32'd0, 32'h0000_0020};
        apply("R4 oor32", 1'b0, 1'b1, d, c);
        // R5: 0x1_0000_0001 clears, 63 and 64 boundary
        d = {4{64'hFFFF_FFFF_FFFF_FFFF}};
        c = {64'h1_0000_0001, 64'd63, 64'd64, 64'd65};
        apply("R5 oor64", 1'b1, 1'b1, d, c);
        // R6: narrow, upper data non-zero
        d = {8{32'hA5A5_5A5A}};
        c = {8{32'd3}};
        apply("R6 narrow32", 1'b0, 1'b0, d, c);
        apply("R6 narrow64", 1'b1, 1'b0, d, {4{64'd7}});
        // R7: zero count passes through
        d = rand_vec();
        apply("R7 zero32", 1'b0, 1'b1, d, '0);
        apply("R7 zero64", 1'b1, 1'b1, d, '0);

        // R8: valid_in low holds result, valid_out drops
        valid_in = 1'b0; data_in = rand_vec(); count_in = '0;
        @(negedge clk);
        check("R8 hold", last_exp, 1'b0);
        @(negedge clk);
        check("R8 hold2", last_exp, 1'b0);

        // R1 R2 R4 R5 R6: random sweep with boundary counts
        for (int t = 0; t < 400; t++) begin
            logic e64 = t[0];
            logic w = t[1] | t[2];
            int lw = e64 ? 64 : 32;
            d = rand_vec();
            c = '0;
            for (int k = 0; k < 256 / lw; k++) begin
                logic [63:0] cv = pick_count(lw);
                if (lw == 32) c[k*32 +: 32] = cv[31:0];
                else c[k*64 +: 64] = cv;
            end
            apply("R1 R2 R4 R5 R6 random", e64, w, d, c);
        end

        // R9: reset after activity
        rst = 1'b1; valid_in = 1'b1;
        @(negedge clk);
        check("R9 reset again", '0, 1'b0);
        rst = 1'b0; valid_in = 1'b0;

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule